// File: doc/BRIEF.md
# Paged Receive Ring Buffer Manager

This block places incoming frames into a circular region of packet RAM that is carved into 256-byte pages. Two configuration inputs name the first page of the ring and the page just past its end. Frame bytes arrive one per cycle on a valid/last stream. Each frame is written beginning four bytes into the page named by the current-page pointer, and the stream wraps from the last ring page back to the first.

After the final byte of a frame has been written, the block fills the four reserved bytes at the front of the frame's first page with a link header: a status byte, the page where the next frame will begin, and the 16-bit byte count split into low and high bytes. Only then does the current-page pointer move to the next page. The host consumes frames and returns space by writing the boundary pointer. The boundary names the page just before the oldest unread frame.

A frame that would run into the boundary page is abandoned. Its bytes stop reaching the RAM, no header is written, the current pointer does not move, and a one-cycle overwrite warning is raised. The block assumes at least four idle stream cycles after each last byte, during which the header is written. It also assumes the host never places the boundary on a page that a frame is currently being written into.

Top module: `rx_page_ring`

## Requirements
- R1: On reset, the current page becomes the start page plus 1, the boundary becomes the start page, the ring reads empty and no RAM write is issued.
- R2: The first data byte of a frame is written at byte offset 4 of the current page, and each following byte is written at the next address, one RAM write for each accepted beat. Idle cycles inside a frame are allowed.
- R3: A data byte that follows offset 255 of page stop-1 is written at offset 0 of the start page. Every RAM write falls inside [start, stop) pages.
- R4: In the four cycles after a frame's last data write, the header is written at offsets 0, 1, 2 and 3 of the frame's first page, in that order.
- R5: Header bytes 2 (low) and 3 (high) hold the frame's data length plus 4.
- R6: Header byte 1 and the new current page both equal the page after the frame's last written page, wrapped into the ring. The current page changes only in the cycle that offset 3 of the header is written.
- R7: The status byte is 0x01 (bit 0, intact) when the FIFO-overrun input is low on the last beat, and 0x08 (bit 3, overrun) when it is high.
- R8: A boundary write takes effect on the next cycle. ring_empty is 1 exactly when the current page equals the boundary plus 1, wrapping from stop-1 to start.
- R9: If a frame's data would cross into the boundary page, that byte and the rest of the frame are not written, no header is written, the current page is kept, and ovw_warn pulses for exactly one cycle. No RAM write ever targets the boundary page.
- R10: A frame whose following page would equal the boundary is dropped in the same way as in R9, even though its data fit.
- R11: The frame after a dropped one starts at offset 4 of the unchanged current page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_pstart | input | PAGE_W | First page of the ring |
| cfg_pstop | input | PAGE_W | Page just past the ring |
| in_valid | input | 1 | Stream byte valid |
| in_data | input | 8 | Stream byte |
| in_last | input | 1 | Final byte of frame |
| in_fifo_ovr | input | 1 | FIFO overrun seen, sampled with the last byte |
| host_bnd_we | input | 1 | Boundary write strobe |
| host_bnd_val | input | PAGE_W | New boundary page |
| mem_we | output | 1 | RAM write enable |
| mem_addr | output | PAGE_W+8 | RAM byte address (page, offset) |
| mem_wdata | output | 8 | RAM write byte |
| cur_page | output | PAGE_W | Current-page pointer |
| bnd_page | output | PAGE_W | Boundary pointer |
| ring_empty | output | 1 | No unread frame in ring |
| ovw_warn | output | 1 | One-cycle pulse when a frame is dropped |

## Verification
A wrong write pointer shows on mem_addr within one cycle of the first misplaced byte. A corrupted page-step or wrap shows as data landing outside the ring or in the wrong page, and also as a wrong next-page byte in the header four cycles after the last beat. A wrong drop decision shows as a header or pointer advance that should not happen, or as a missing one, once the header window has passed. It also shows as a write into the boundary page, which the RAM contents expose before the host could read the frame. Sweeping frame lengths around page edges from every ring position catches off-by-one count and next-page errors on the first frame that straddles the affected edge.

// File: rtl/rxr_pkg.sv
// Shared types and constants for the paged receive ring.
// Assumes 256-byte pages and a 4-byte per-frame link header.
package rxr_pkg;
    localparam int OFF_W     = 8;   // byte offset within a page
    localparam int CNT_W     = 16;  // header byte count width
    localparam int HDR_BYTES = 4;
    localparam int INTACT_BIT = 0;
    localparam int FOVR_BIT   = 3;

    typedef enum logic [1:0] {
        WS_IDLE,
        WS_DATA,
        WS_HDR,
        WS_DROP
    } wr_state_e;
endpackage

// File: rtl/rxr_ptrs.sv
// Current-page and boundary registers with the empty indication.
// Assumes cfg_pstart < cfg_pstop and both stay stable while running.
module rxr_ptrs #(
    parameter int PAGE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PAGE_W-1:0] cfg_pstart,
    input  logic [PAGE_W-1:0] cfg_pstop,
    input  logic              adv,
    input  logic [PAGE_W-1:0] adv_page,
    input  logic              bnd_we,
    input  logic [PAGE_W-1:0] bnd_val,
    output logic [PAGE_W-1:0] cur_q,
    output logic [PAGE_W-1:0] bnd_q,
    output logic              empty
);
    function automatic logic [PAGE_W-1:0] step(input logic [PAGE_W-1:0] p);
        logic [PAGE_W-1:0] n;
        n = p + 1'b1;
        return (n == cfg_pstop) ? cfg_pstart : n;
    endfunction

    // Load pointers at reset; follow writer advances and host boundary writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q <= cfg_pstart + 1'b1;
            bnd_q <= cfg_pstart;
        end else begin
            if (adv)
                cur_q <= adv_page;
            if (bnd_we)
                bnd_q <= bnd_val;
        end
    end

    // Ring is empty when the next unread page is the one being filled.
    always_comb empty = (cur_q == step(bnd_q));
endmodule

// File: rtl/rxr_writer.sv
// Frame writer: streams bytes into pages, detects boundary collision,
// then writes the 4-byte header. Assumes >= 4 idle stream cycles after
// every last beat. RAM port outputs are registered.
module rxr_writer
    import rxr_pkg::*;
#(
    parameter int PAGE_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [PAGE_W-1:0]       cfg_pstart,
    input  logic [PAGE_W-1:0]       cfg_pstop,
    input  logic [PAGE_W-1:0]       cur,
    input  logic [PAGE_W-1:0]       bnd,
    input  logic                    in_valid,
    input  logic [7:0]              in_data,
    input  logic                    in_last,
    input  logic                    in_fifo_ovr,
    output logic                    mem_we,
    output logic [PAGE_W+OFF_W-1:0] mem_addr,
    output logic [7:0]              mem_wdata,
    output logic                    adv,
    output logic [PAGE_W-1:0]       adv_page,
    output logic                    ovw
);
    wr_state_e          st_q;
    logic [PAGE_W-1:0]  pg_q, nxt_q;
    logic [OFF_W-1:0]   off_q;
    logic [CNT_W-1:0]   cnt_q;
    logic [1:0]         hidx_q;
    logic [7:0]         stat_q;

    logic [PAGE_W-1:0]  eff_pg, tgt_pg, nxt_pg;
    logic [OFF_W-1:0]   eff_off;
    logic [CNT_W-1:0]   eff_cnt;
    logic               crossing, blk_cross, blk_end;
    logic [7:0]         hdr_byte;

    function automatic logic [PAGE_W-1:0] step(input logic [PAGE_W-1:0] p);
        logic [PAGE_W-1:0] n;
        n = p + 1'b1;
        return (n == cfg_pstop) ? cfg_pstart : n;
    endfunction

    // Position of the incoming beat; a new frame starts past the header.
    always_comb begin
        eff_pg    = (st_q == WS_IDLE) ? cur : pg_q;
        eff_off   = (st_q == WS_IDLE) ? OFF_W'(HDR_BYTES) : off_q;
        eff_cnt   = (st_q == WS_IDLE) ? CNT_W'(HDR_BYTES) : cnt_q;
        crossing  = (eff_off == '0);
        tgt_pg    = crossing ? step(eff_pg) : eff_pg;
        nxt_pg    = step(tgt_pg);
        blk_cross = crossing && (tgt_pg == bnd);
        blk_end   = in_last && (nxt_pg == bnd);
    end

    // Header byte selected by the header write index.
    always_comb begin
        case (hidx_q)
            2'd0:    hdr_byte = stat_q;
            2'd1:    hdr_byte = 8'(nxt_q);
            2'd2:    hdr_byte = cnt_q[7:0];
            default: hdr_byte = cnt_q[15:8];
        endcase
    end

    // Pointer advance coincides with the final header write.
    always_comb begin
        adv      = (st_q == WS_HDR) && (hidx_q == 2'd3);
        adv_page = nxt_q;
    end

    // Frame sequencing, data/header RAM writes and drop handling.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= WS_IDLE;
            mem_we    <= 1'b0;
            mem_addr  <= '0;
            mem_wdata <= '0;
            ovw       <= 1'b0;
            pg_q      <= '0;
            nxt_q     <= '0;
            off_q     <= '0;
            cnt_q     <= '0;
            hidx_q    <= '0;
            stat_q    <= '0;
        end else begin
            mem_we <= 1'b0;
            ovw    <= 1'b0;
            case (st_q)
                WS_IDLE, WS_DATA: begin
                    if (in_valid) begin
                        if (!blk_cross) begin
                            mem_we    <= 1'b1;
                            mem_addr  <= {tgt_pg, eff_off};
                            mem_wdata <= in_data;
                        end
                        if (blk_cross || blk_end) begin
                            ovw  <= 1'b1;
                            st_q <= in_last ? WS_IDLE : WS_DROP;
                        end else if (in_last) begin
                            st_q   <= WS_HDR;
                            nxt_q  <= nxt_pg;
                            cnt_q  <= eff_cnt + 1'b1;
                            hidx_q <= '0;
                            stat_q <= in_fifo_ovr ? 8'(1 << FOVR_BIT)
                                                  : 8'(1 << INTACT_BIT);
                        end else begin
                            st_q  <= WS_DATA;
                            pg_q  <= tgt_pg;
                            off_q <= eff_off + 1'b1;
                            cnt_q <= eff_cnt + 1'b1;
                        end
                    end
                end
                WS_DROP: begin
                    if (in_valid && in_last)
                        st_q <= WS_IDLE;
                end
                default: begin
                    mem_we    <= 1'b1;
                    mem_addr  <= {cur, 6'd0, hidx_q};
                    mem_wdata <= hdr_byte;
                    hidx_q    <= hidx_q + 1'b1;
                    if (hidx_q == 2'd3)
                        st_q <= WS_IDLE;
                end
            endcase
        end
    end
endmodule

// File: rtl/rx_page_ring.sv
// Top of the paged receive ring manager: joins the frame writer to the
// pointer registers. RAM is external; one byte write per cycle.
module rx_page_ring
    import rxr_pkg::*;
#(
    parameter int PAGE_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [PAGE_W-1:0]       cfg_pstart,
    input  logic [PAGE_W-1:0]       cfg_pstop,
    input  logic                    in_valid,
    input  logic [7:0]              in_data,
    input  logic                    in_last,
    input  logic                    in_fifo_ovr,
    input  logic                    host_bnd_we,
    input  logic [PAGE_W-1:0]       host_bnd_val,
    output logic                    mem_we,
    output logic [PAGE_W+OFF_W-1:0] mem_addr,
    output logic [7:0]              mem_wdata,
    output logic [PAGE_W-1:0]       cur_page,
    output logic [PAGE_W-1:0]       bnd_page,
    output logic                    ring_empty,
    output logic                    ovw_warn
);
    logic              adv;
    logic [PAGE_W-1:0] adv_page;

    rxr_ptrs #(.PAGE_W(PAGE_W)) ptrs_i (
        .clk(clk), .rst_n(rst_n),
        .cfg_pstart(cfg_pstart), .cfg_pstop(cfg_pstop),
        .adv(adv), .adv_page(adv_page),
        .bnd_we(host_bnd_we), .bnd_val(host_bnd_val),
        .cur_q(cur_page), .bnd_q(bnd_page), .empty(ring_empty)
    );

    rxr_writer #(.PAGE_W(PAGE_W)) writer_i (
        .clk(clk), .rst_n(rst_n),
        .cfg_pstart(cfg_pstart), .cfg_pstop(cfg_pstop),
        .cur(cur_page), .bnd(bnd_page),
        .in_valid(in_valid), .in_data(in_data), .in_last(in_last),
        .in_fifo_ovr(in_fifo_ovr),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .adv(adv), .adv_page(adv_page), .ovw(ovw_warn)
    );
endmodule

// File: rtl/rx_page_ring_chk.sv
// Port-level checker for rx_page_ring, attached by bind.
// Assumes the host never moves the boundary onto a page under write.
module rx_page_ring_chk
    import rxr_pkg::*;
#(
    parameter int PAGE_W = 8
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [PAGE_W-1:0]       cfg_pstart,
    input logic [PAGE_W-1:0]       cfg_pstop,
    input logic                    host_bnd_we,
    input logic [PAGE_W-1:0]       host_bnd_val,
    input logic                    mem_we,
    input logic [PAGE_W+OFF_W-1:0] mem_addr,
    input logic [PAGE_W-1:0]       cur_page,
    input logic [PAGE_W-1:0]       bnd_page,
    input logic                    ovw_warn
);
    localparam int AW = PAGE_W + OFF_W;

    // R8
    bnd_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_bnd_we |=> (bnd_page == $past(host_bnd_val)));

    // R9
    ovw_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovw_warn |=> !ovw_warn);

    // R9
    ovw_keep_cur_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovw_warn |-> (cur_page == $past(cur_page)));

    // R9
    no_bnd_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_addr[AW-1:OFF_W] != bnd_page));

    // R3
    in_ring_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> ((mem_addr[AW-1:OFF_W] >= cfg_pstart) &&
                    (mem_addr[AW-1:OFF_W] <  cfg_pstop)));

    // R6
    cur_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_page != $past(cur_page)) |-> (mem_we && (mem_addr[OFF_W-1:0] == 8'd3)));
endmodule

bind rx_page_ring rx_page_ring_chk #(.PAGE_W(PAGE_W)) chk_i (.*);

// File: tb/rx_page_ring_tb_top.sv
// Sweeps frame lengths around page edges through a 6-page ring,
// checking RAM contents, header, pointers and drop behaviour.
module rx_page_ring_tb_top;
    localparam int START = 2;
    localparam int STOP  = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  cfg_pstart = 8'(START);
    logic [7:0]  cfg_pstop  = 8'(STOP);
    logic        in_valid = 1'b0, in_last = 1'b0, in_fifo_ovr = 1'b0;
    logic [7:0]  in_data = '0;
    logic        host_bnd_we = 1'b0;
    logic [7:0]  host_bnd_val = '0;
    logic        mem_we, ring_empty, ovw_warn;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata, cur_page, bnd_page;

    int total = 0, bad = 0, cyc = 0;
    int ovw_cnt = 0, bnd_hits = 0;
    int exp_cur = START + 1, exp_bnd = START;
    logic [7:0] mem [0:2047];

    always #4 clk = ~clk;

    rx_page_ring dut_i (.*);

    // RAM model and event counters, sampled away from the active edge.
    always @(negedge clk) begin
        if (mem_we) begin
            mem[mem_addr[10:0]] = mem_wdata;
            if (mem_addr[15:8] == bnd_page) bnd_hits++;
        end
        if (ovw_warn) ovw_cnt++;
    end

    // Watchdog.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            bad++; total++;
            $display("FAIL watchdog: act=%0d exp<150000 cycles", cyc);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    function automatic int step(int p);
        return (p + 1 == STOP) ? START : p + 1;
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
        end
    endtask

    task automatic send_frame(int len, bit ovr, int seed, bit gaps, string dtag);
        int pages, p, nxt, ovw0, hits0, errs, base;
        bit drop, wraps;
        pages = (len + 3) / 256 + 1;
        p = exp_cur; drop = 0; wraps = 0;
        for (int k = 1; k <= pages; k++) begin
            p = step(p);
            if (p == START && k < pages) wraps = 1;
            if (p == exp_bnd) drop = 1;
        end
        nxt = p;
        ovw0 = ovw_cnt; hits0 = bnd_hits;
        for (int i = 0; i < len; i++) begin
            if (gaps && (i % 5 == 2)) begin
                @(negedge clk); in_valid = 1'b0;
            end
            @(negedge clk);
            in_valid = 1'b1; in_data = 8'((i * 7 + seed) & 255);
            in_last = (i == len - 1); in_fifo_ovr = ovr;
        end
        @(negedge clk); in_valid = 1'b0; in_last = 1'b0; in_fifo_ovr = 1'b0;
        repeat (8) @(negedge clk);
        check(bnd_hits == hits0, "R9 no write in boundary page", bnd_hits - hits0, 0);
        if (drop) begin
            check(ovw_cnt == ovw0 + 1, (len + 3) / 256 + 1 == 5 ? "R10 drop warn" : "R9 drop warn",
                  ovw_cnt - ovw0, 1);
            check(cur_page == 8'(exp_cur), "R9 cur kept on drop", cur_page, exp_cur);
        end else begin
            base = exp_cur * 256;
            check(ovw_cnt == ovw0, "R9 no warn", ovw_cnt - ovw0, 0);
            check(cur_page == 8'(nxt), "R6 cur advanced", cur_page, nxt);
            check(mem[base + 1] == 8'(nxt), "R6 header next", mem[base + 1], nxt);
            check(mem[base + 0] == (ovr ? 8'h08 : 8'h01), "R7 status", mem[base],
                  ovr ? 8 : 1);
            check({mem[base + 3], mem[base + 2]} == 16'(len + 4), "R5 R4 byte count",
                  {mem[base + 3], mem[base + 2]}, len + 4);
            errs = 0;
            for (int i = 0; i < len; i++) begin
                int pos, pg;
                pos = 4 + i; pg = exp_cur;
                for (int j = 0; j < pos / 256; j++) pg = step(pg);
                if (mem[pg * 256 + pos % 256] != 8'((i * 7 + seed) & 255)) errs++;
            end
            check(errs == 0, wraps ? "R3 data wrapped" : dtag, errs, 0);
            check(ring_empty == 1'b0, "R8 not empty after frame", ring_empty, 0);
            exp_cur = nxt;
        end
    endtask

    task automatic free_all();
        exp_bnd = (exp_cur == START) ? STOP - 1 : exp_cur - 1;
        @(negedge clk); host_bnd_we = 1'b1; host_bnd_val = 8'(exp_bnd);
        @(negedge clk); host_bnd_we = 1'b0;
        check(bnd_page == 8'(exp_bnd), "R8 boundary load", bnd_page, exp_bnd);
        check(ring_empty == 1'b1, "R8 empty after free", ring_empty, 1);
    endtask

    initial begin
        int lens [13] = '{1, 60, 251, 252, 253, 256, 507, 508, 509, 1000, 1020, 1021, 700};
        int old_cur;
        repeat (3) @(negedge clk);
        check(cur_page == 8'(START + 1), "R1 reset cur", cur_page, START + 1);
        check(bnd_page == 8'(START), "R1 reset boundary", bnd_page, START);
        check(ring_empty == 1'b1, "R1 reset empty", ring_empty, 1);
        check(mem_we == 1'b0, "R1 no write in reset", mem_we, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Length sweep from a freed ring each time, moving around all pages.
        for (int r = 0; r < 2; r++) begin
            foreach (lens[n]) begin
                send_frame(lens[n], (n % 3) == 1, n + 17 * r, (n == 8), "R2 data");
                free_all();
            end
        end

        // Fill without freeing until a crossing into the boundary drops a frame.
        send_frame(300, 1'b0, 3, 1'b0, "R2 data");
        send_frame(300, 1'b0, 4, 1'b0, "R2 data");
        old_cur = exp_cur;
        send_frame(300, 1'b0, 5, 1'b0, "R2 data");
        check(exp_cur == old_cur, "R9 model drop", exp_cur, old_cur);
        free_all();
        send_frame(100, 1'b0, 9, 1'b0, "R11 restart after drop");
        check(mem[old_cur * 256 + 4] == 8'(9), "R11 first byte at offset 4",
              mem[old_cur * 256 + 4], 9);
        free_all();

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule